// File: doc/BRIEF.md
# Lane Read-Only Cache Group with Peer Miss Fill

This block holds one small read-only cache per processing lane (four lanes by default) and a single shared miss handler. Entries enter a cache only through an explicit load command from the controller, and leave only through an explicit invalidate command. A lane read that hits returns its word one cycle later. Nothing ever overwrites an entry that is already present.

When any lane misses, the handler raises a common stall that freezes every lane. It records which lanes missed and what each one wanted. It then services the missing lanes one at a time, lowest lane first. For each missing lane it probes all the lanes that did not miss, in parallel. If a peer holds the word, that word is copied into the missing cache in one cycle. If no peer holds it, a single word is fetched from backing memory.

Each cache is fully associative and replaces its least-recently-used way. Once the last fill has been written, the stall drops. The lanes, which keep their requests asserted throughout the stall, are then replayed and hit.

Top module: `ro_lane_cache`

## Requirements
- R1: A lane read (acc_valid bit set, lane address in acc_addr bits [l*32 +: 32]) to an address held by that lane returns rd_valid for the lane one cycle later, with the stored word in rd_data bits [l*32 +: 32], and stall stays low.
- R2: If any lane's read misses while stall is low, stall is high in the next cycle. While stall is high, miss_flag has a bit set for each lane that missed, and miss_addr bits [l*32 +: 32] hold lane l's missed address. Both are zero while stall is low.
- R3: If a lane that did not miss holds the missed address, the word is copied from that peer, and no memory request is made.
- R4: If no peer holds the address, mem_req rises with mem_addr equal to the missed address. mem_req and mem_addr are held until mem_rvalid, and exactly one word is fetched. The replayed read returns mem_rdata.
- R5: Lanes that miss in the same cycle are serviced one at a time in ascending lane order, so their memory fetches appear in that order.
- R6: A fill or load into a full cache evicts the way least recently touched by a read hit, fill or load.
- R7: Probing a peer cache does not change that cache's LRU order.
- R8: A load of an address that the lane already holds is ignored, and the stored word is kept.
- R9: An invalidate with inval_mask bit l set empties lane l, so that lane's next read misses. Other lanes keep their contents.
- R10: Load and invalidate commands presented while stall is high are ignored.
- R11: After reset, stall, rd_valid and mem_req are low and every cache is empty.
- R12: Stall drops in the cycle after the last fill is written. For a single miss served by a peer, stall is high for exactly one cycle and the result appears three cycles after the read was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 4 | Per-lane read request, held while stall is high |
| acc_addr | input | 128 | Per-lane read address, lane l at [l*32 +: 32] |
| rd_valid | output | 4 | Per-lane read result valid |
| rd_data | output | 128 | Per-lane read result, lane l at [l*32 +: 32] |
| stall | output | 1 | Freeze for every lane while a miss is being serviced |
| miss_flag | output | 4 | Lanes that missed, shown during stall |
| miss_addr | output | 128 | Missed address per lane, shown during stall |
| load_valid | input | 1 | Explicit load command |
| load_lane | input | 2 | Lane targeted by the load |
| load_addr | input | 32 | Address of the loaded word |
| load_data | input | 32 | Loaded word |
| inval_valid | input | 1 | Explicit invalidate command |
| inval_mask | input | 4 | Lanes emptied by the invalidate |
| mem_req | output | 1 | Backing memory fetch request |
| mem_addr | output | 32 | Backing memory fetch address |
| mem_rvalid | input | 1 | Backing memory word valid |
| mem_rdata | input | 32 | Backing memory word |

## Verification
A hit is due one edge after the read is presented. A miss shows up as stall one edge later. A peer fill takes one more edge, the replay one more after that, so the result is due three edges after the read. A memory fill waits for the model's response, which comes two cycles after it sees mem_req. The bench drives on the falling edge and samples on the next falling edge, and it counts those edges. It checks exact latencies where the requirement fixes them, and the stall-cycle count for the peer case. Elsewhere it waits for rd_valid within a bound. The memory model logs every fetched address, which lets the bench check whether memory was used and in what order.

// File: rtl/ro_lane_cache.sv
module ro_lane_cache #(
  parameter int LANES = 4,
  parameter int WAYS  = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         acc_valid,
  input  logic [LANES*AW-1:0]      acc_addr,
  output logic [LANES-1:0]         rd_valid,
  output logic [LANES*DW-1:0]      rd_data,
  output logic                     stall,
  output logic [LANES-1:0]         miss_flag,
  output logic [LANES*AW-1:0]      miss_addr,
  input  logic                     load_valid,
  input  logic [$clog2(LANES)-1:0] load_lane,
  input  logic [AW-1:0]            load_addr,
  input  logic [DW-1:0]            load_data,
  input  logic                     inval_valid,
  input  logic [LANES-1:0]         inval_mask,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_rvalid,
  input  logic [DW-1:0]            mem_rdata
);
  localparam int LW = $clog2(LANES);
  localparam int WW = $clog2(WAYS);
  localparam logic [WW-1:0] OLDEST = WW'(WAYS - 1);

  typedef enum logic [1:0] {IDLE, SVC, FETCH} st_t;
  st_t st;

  logic          vld [LANES][WAYS];
  logic [AW-1:0] tag [LANES][WAYS];
  logic [DW-1:0] dat [LANES][WAYS];
  logic [WW-1:0] age [LANES][WAYS];

  logic [LANES-1:0] miss_q, pend, nxt_pend;
  logic [AW-1:0]    maddr_q [LANES];
  logic [DW-1:0]    rd_q    [LANES];
  logic [LW-1:0]    cur;
  logic [AW-1:0]    svc_addr;

  logic [LANES-1:0] acc_hit, prb_hit, ld_hit, vic_free, fill_we, ld_we, wr, touch;
  logic [WW-1:0]    acc_way [LANES];
  logic [WW-1:0]    vic     [LANES];
  logic [WW-1:0]    tw      [LANES];
  logic [DW-1:0]    acc_dat [LANES];
  logic [DW-1:0]    prb_dat [LANES];
  logic             peer_found, any_miss, accept;
  logic [DW-1:0]    peer_dat, fill_dat;

  always_comb begin
    cur = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (pend[l]) cur = LW'(l);
  end

  assign svc_addr = maddr_q[cur];
  assign nxt_pend = pend & ~(LANES'(1) << cur);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      acc_hit[l]  = 1'b0;
      acc_way[l]  = '0;
      acc_dat[l]  = '0;
      prb_hit[l]  = 1'b0;
      prb_dat[l]  = '0;
      ld_hit[l]   = 1'b0;
      vic_free[l] = 1'b0;
      vic[l]      = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (vld[l][w] && tag[l][w] == acc_addr[l*AW +: AW]) begin
          acc_hit[l] = 1'b1;
          acc_way[l] = WW'(w);
          acc_dat[l] = dat[l][w];
        end
        if (vld[l][w] && tag[l][w] == svc_addr) begin
          prb_hit[l] = 1'b1;
          prb_dat[l] = dat[l][w];
        end
        if (vld[l][w] && tag[l][w] == load_addr) ld_hit[l] = 1'b1;
      end
      for (int w = WAYS - 1; w >= 0; w--)
        if (!vld[l][w]) begin
          vic_free[l] = 1'b1;
          vic[l]      = WW'(w);
        end
      if (!vic_free[l])
        for (int w = 0; w < WAYS; w++)
          if (age[l][w] == OLDEST) vic[l] = WW'(w);
    end
  end

  always_comb begin
    peer_found = 1'b0;
    peer_dat   = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (prb_hit[l] && !miss_q[l]) begin
        peer_found = 1'b1;
        peer_dat   = prb_dat[l];
      end
  end

  assign stall    = (st != IDLE);
  assign any_miss = |(acc_valid & ~acc_hit);
  assign accept   = (st == IDLE) && !any_miss;
  assign fill_dat = (st == SVC) ? peer_dat : mem_rdata;
  assign mem_req  = (st == FETCH);
  assign mem_addr = svc_addr;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      fill_we[l] = (cur == LW'(l)) &&
                   (((st == SVC) && peer_found) || ((st == FETCH) && mem_rvalid));
      ld_we[l]   = load_valid && !stall && (load_lane == LW'(l)) && !ld_hit[l];
      wr[l]      = fill_we[l] | ld_we[l];
      touch[l]   = accept && acc_valid[l];
      tw[l]      = wr[l] ? vic[l] : acc_way[l];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++)
        for (int w = 0; w < WAYS; w++) begin
          vld[l][w] <= 1'b0;
          tag[l][w] <= '0;
          dat[l][w] <= '0;
          age[l][w] <= WW'(w);
        end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (wr[l]) begin
          vld[l][vic[l]] <= 1'b1;
          tag[l][vic[l]] <= fill_we[l] ? svc_addr : load_addr;
          dat[l][vic[l]] <= fill_we[l] ? fill_dat : load_data;
        end
        if (wr[l] || touch[l])
          for (int w = 0; w < WAYS; w++) begin
            if (WW'(w) == tw[l]) age[l][w] <= '0;
            else if (age[l][w] < age[l][tw[l]]) age[l][w] <= age[l][w] + 1'b1;
          end
        if (inval_valid && !stall && inval_mask[l])
          for (int w = 0; w < WAYS; w++) vld[l][w] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      miss_q   <= '0;
      pend     <= '0;
      rd_valid <= '0;
      for (int l = 0; l < LANES; l++) begin
        maddr_q[l] <= '0;
        rd_q[l]    <= '0;
      end
    end else begin
      rd_valid <= accept ? acc_valid : '0;
      for (int l = 0; l < LANES; l++) rd_q[l] <= acc_dat[l];
      case (st)
        IDLE:
          if (any_miss) begin
            miss_q <= acc_valid & ~acc_hit;
            pend   <= acc_valid & ~acc_hit;
            for (int l = 0; l < LANES; l++) maddr_q[l] <= acc_addr[l*AW +: AW];
            st <= SVC;
          end
        SVC:
          if (peer_found) begin
            pend <= nxt_pend;
            st   <= (nxt_pend == '0) ? IDLE : SVC;
          end else begin
            st <= FETCH;
          end
        FETCH:
          if (mem_rvalid) begin
            pend <= nxt_pend;
            st   <= (nxt_pend == '0) ? IDLE : SVC;
          end
        default: st <= IDLE;
      endcase
    end
  end

  assign miss_flag = stall ? miss_q : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign rd_data[l*DW +: DW]   = rd_q[l];
    assign miss_addr[l*AW +: AW] = miss_flag[l] ? maddr_q[l] : '0;
  end

  // R1
  rd_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_valid) |-> !$past(stall));
  // R2
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && any_miss) |=> stall);
  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  // R4
  mem_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> stall);
  // R5
  one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_we));
  // R12
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> $past(|fill_we));
endmodule

// File: tb/ro_lane_cache_test.sv
module ro_lane_cache_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   acc_valid = '0;
  logic [127:0] acc_addr = '0;
  logic [3:0]   rd_valid;
  logic [127:0] rd_data;
  logic         stall;
  logic [3:0]   miss_flag;
  logic [127:0] miss_addr;
  logic         load_valid = 1'b0;
  logic [1:0]   load_lane = '0;
  logic [31:0]  load_addr = '0;
  logic [31:0]  load_data = '0;
  logic         inval_valid = 1'b0;
  logic [3:0]   inval_mask = '0;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rvalid = 1'b0;
  logic [31:0]  mem_rdata = '0;

  int checks = 0, errors = 0;
  int nf = 0, mcnt = 0;
  logic [31:0] flog [0:15];

  logic [3:0]   r_valid, mf0;
  logic [127:0] r_data, ma0;
  logic         st0;
  int           scyc, lat;

  ro_lane_cache uut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      mcnt = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0;
    end else if (mem_req) begin
      mcnt++;
      if (mcnt == 2) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memf(mem_addr);
        if (nf < 16) flog[nf] = mem_addr;
        nf++;
        mcnt = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] ln, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    load_valid = 1'b1; load_lane = ln; load_addr = a; load_data = d;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic inval(input logic [3:0] m);
    @(negedge clk);
    inval_valid = 1'b1; inval_mask = m;
    @(negedge clk);
    inval_valid = 1'b0;
  endtask

  task automatic access(input logic [3:0] vm, input logic [31:0] a0, input logic [31:0] a1,
                        input logic [31:0] a2, input logic [31:0] a3, input bit side);
    @(negedge clk);
    acc_valid = vm;
    acc_addr  = {a3, a2, a1, a0};
    scyc = 0; lat = 0; r_valid = '0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (stall) scyc++;
      if (k == 0) begin
        st0 = stall; mf0 = miss_flag; ma0 = miss_addr;
        if (side) begin
          load_valid = 1'b1; load_lane = 2'd2; load_addr = 32'h700; load_data = 32'h7777;
          inval_valid = 1'b1; inval_mask = 4'b0010;
        end
      end
      if (k == 1) begin
        load_valid = 1'b0; inval_valid = 1'b0;
      end
      if (rd_valid != '0) begin
        r_valid = rd_valid; r_data = rd_data; lat = k + 1;
        break;
      end
    end
    acc_valid = '0;
  endtask

  task automatic t_reset();
    chk("R11 stall", 32'(stall), 0);
    chk("R11 rd_valid", 32'(rd_valid), 0);
    chk("R11 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_hit();
    load(2'd1, 32'h200, 32'h2222);
    access(4'b0010, 0, 32'h200, 0, 0, 0);
    chk("R1 no stall", 32'(st0), 0);
    chk("R1 latency", lat, 1);
    chk("R1 valid", 32'(r_valid), 32'b0010);
    chk("R1 data", r_data[63:32], 32'h2222);
  endtask

  task automatic t_mem();
    access(4'b0001, 32'h100, 0, 0, 0, 0);
    chk("R11 empty cache misses", 32'(st0), 1);
    chk("R2 miss_flag", 32'(mf0), 32'b0001);
    chk("R2 miss_addr", ma0[31:0], 32'h100);
    chk("R4 one fetch", nf, 1);
    chk("R4 fetch addr", flog[0], 32'h100);
    chk("R4 data", r_data[31:0], memf(32'h100));
    chk("R2 flags clear after", 32'(miss_flag), 0);
  endtask

  task automatic t_peer();
    access(4'b0100, 0, 0, 32'h200, 0, 0);
    chk("R3 no fetch", nf, 1);
    chk("R3 data", r_data[95:64], 32'h2222);
    chk("R12 stall cycles", scyc, 1);
    chk("R12 latency", lat, 3);
  endtask

  task automatic t_multi();
    access(4'b1001, 32'h300, 0, 0, 32'h280, 0);
    chk("R2 two flags", 32'(mf0), 32'b1001);
    chk("R2 lane3 addr", ma0[127:96], 32'h280);
    chk("R5 fetch count", nf, 3);
    chk("R5 first lane0", flog[1], 32'h300);
    chk("R5 then lane3", flog[2], 32'h280);
    chk("R5 both replay", 32'(r_valid), 32'b1001);
    chk("R5 data lane0", r_data[31:0], memf(32'h300));
    chk("R5 data lane3", r_data[127:96], memf(32'h280));
  endtask

  task automatic t_lru();
    load(2'd3, 32'h400, 32'h4000);
    load(2'd3, 32'h404, 32'h4040);
    load(2'd3, 32'h408, 32'h4080);
    access(4'b1000, 0, 0, 0, 32'h280, 0);
    chk("R6 touch hit", 32'(st0), 0);
    load(2'd3, 32'h40C, 32'h40C0);
    access(4'b1000, 0, 0, 0, 32'h404, 0);
    chk("R6 kept 404", 32'(st0), 0);
    chk("R6 data 404", r_data[127:96], 32'h4040);
    access(4'b1000, 0, 0, 0, 32'h280, 0);
    chk("R6 kept 280", 32'(st0), 0);
    access(4'b1000, 0, 0, 0, 32'h400, 0);
    chk("R6 evicted 400", 32'(st0), 1);
    chk("R6 refetch data", r_data[127:96], memf(32'h400));
  endtask

  task automatic t_probe();
    int n0;
    load(2'd1, 32'h210, 32'h2100);
    load(2'd1, 32'h220, 32'h2200);
    load(2'd1, 32'h230, 32'h2300);
    n0 = nf;
    access(4'b0001, 32'h200, 0, 0, 0, 0);
    chk("R7 lane0 missed", 32'(st0), 1);
    chk("R3 peer data", r_data[31:0], 32'h2222);
    chk("R3 peer no fetch", nf, n0);
    load(2'd1, 32'h240, 32'h2400);
    access(4'b0010, 0, 32'h210, 0, 0, 0);
    chk("R7 210 kept", 32'(st0), 0);
    chk("R7 210 data", r_data[63:32], 32'h2100);
    access(4'b0010, 0, 32'h200, 0, 0, 0);
    chk("R7 200 evicted", 32'(st0), 1);
    chk("R7 refill from peer", r_data[63:32], 32'h2222);
  endtask

  task automatic t_readonly();
    load(2'd1, 32'h210, 32'h0BAD);
    access(4'b0010, 0, 32'h210, 0, 0, 0);
    chk("R8 hit", 32'(st0), 0);
    chk("R8 word kept", r_data[63:32], 32'h2100);
  endtask

  task automatic t_stall_cmds();
    access(4'b0100, 0, 0, 32'h600, 0, 1);
    chk("R10 miss served", r_data[95:64], memf(32'h600));
    access(4'b0010, 0, 32'h210, 0, 0, 0);
    chk("R10 inval ignored", 32'(st0), 0);
    chk("R10 lane1 data", r_data[63:32], 32'h2100);
    access(4'b0100, 0, 0, 32'h700, 0, 0);
    chk("R10 load ignored", 32'(st0), 1);
    chk("R10 memory word", r_data[95:64], memf(32'h700));
  endtask

  task automatic t_inval();
    inval(4'b0010);
    access(4'b0010, 0, 32'h210, 0, 0, 0);
    chk("R9 lane1 emptied", 32'(st0), 1);
    chk("R9 refetch", r_data[63:32], memf(32'h210));
    access(4'b0100, 0, 0, 32'h600, 0, 0);
    chk("R9 lane2 kept", 32'(st0), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_hit();
    t_mem();
    t_peer();
    t_multi();
    t_lru();
    t_probe();
    t_readonly();
    t_stall_cmds();
    t_inval();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule